// File: doc/BRIEF.md
# Dual-Mode Memory Protection Unit

This block sits next to a simple processor pipeline and enforces a two-level privilege scheme. It holds a single mode flag, which selects either the privileged monitor mode or the unprivileged user mode. It also holds a pair of bound registers, a base and a size, that describe the one window of physical addresses a user program may touch. On every clock it looks at the memory access and the instruction-class flags that the pipeline presents. When it finds a violation, or sees a system call or an external interrupt, it raises a one-cycle trap request with a cause code. In the same cycle it drops the mode flag back to monitor mode, so the handler always runs privileged.

The pipeline flags every privileged instruction on `priv_op`, and this includes all I/O instructions. It also signals loads of the two bound registers and the return-to-user operation on their own inputs. In monitor mode these operations take effect. In user mode they are suppressed and turn into an illegal-instruction trap. Only user-mode accesses go through the range check. Monitor-mode accesses are never checked.

Top module: `priv_guard`

## Requirements
- R1: After reset the mode output `user_mode` is 0 (monitor), `trap_req` is 0, and base and size both hold 0, so every user access traps until the bounds are loaded.
- R2: `user_mode` is 0 in monitor mode and 1 in user mode. A `ret_user` seen in monitor mode without any trap event sets it to 1 at the next edge. It becomes 1 by no other means.
- R3: `trap_req` and `trap_cause` are registered. A trap event at a clock edge makes `trap_req` 1 for the following cycle, and at that same edge `user_mode` becomes 0. `trap_req` returns to 0 after a cycle with no event, and `trap_cause` is then 0.
- R4: `priv_op` in user mode raises cause 1 (illegal instruction). In monitor mode it raises nothing.
- R5: A user access is legal when base <= address < base + size, so the first address is included and the end address is excluded.
- R6: A user access (`acc_valid`=1) outside the legal window raises cause 2 (address violation).
- R7: `ld_base` and `ld_limit` write `ld_data` into the bound registers only in monitor mode. In user mode the registers keep their value and cause 1 is raised.
- R8: In monitor mode no access raises cause 2, whatever its address.
- R9: `sys_call` raises cause 3 and `ext_irq` raises cause 4, in either mode. When several events fall in one cycle, the code reported is the first in the order 2, 1, 3, 4.
- R10: `ret_user` in user mode raises cause 1 and leaves the mode at monitor.
- R11: base + size is formed with one extra bit. A window that reaches past the top address does not wrap, so low addresses stay illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_addr | input | AW | Physical address of the access |
| priv_op | input | 1 | The current instruction is privileged (I/O included) |
| ld_base | input | 1 | Instruction loads the base register |
| ld_limit | input | 1 | Instruction loads the size register |
| ld_data | input | AW | Value for a bound load |
| sys_call | input | 1 | System-call event |
| ext_irq | input | 1 | External interrupt event |
| ret_user | input | 1 | Request to switch to user mode |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 3 | Cause: 0 none, 1 illegal, 2 address, 3 system call, 4 interrupt |
| user_mode | output | 1 | Current mode flag, 1 = user |

## Verification
User accesses are tried at the base address, at the last legal address, at the first address past the end, and just below the base. This separates an off-by-one on either side of the window. A window placed at the top of the address space, with accesses at a low address and at the highest address, shows whether the end sum wraps. A zero size shows whether an empty window is treated as legal. Events are also issued in pairs within one cycle, such as a bad access with a system call or a privileged instruction with an interrupt. These pairs check the priority order. Bound loads attempted from user mode, followed by an access that depends on the old base, show that a suppressed load had no effect.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_ILLEGAL = 3'd1,
      CAUSE_ADDR    = 3'd2,
      CAUSE_SYSCALL = 3'd3,
      CAUSE_IRQ     = 3'd4
   } cause_e;

   localparam logic MODE_MON  = 1'b0;
   localparam logic MODE_USER = 1'b1;
endpackage

// File: rtl/pg_bounds.sv
module pg_bounds #(
   parameter int          AW        = 16,
   parameter bit          PRECOMP   = 1'b1,
   parameter logic [AW-1:0] RST_BASE  = '0,
   parameter logic [AW-1:0] RST_LIMIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          user_mode,
   input  logic          ld_base,
   input  logic          ld_limit,
   input  logic [AW-1:0] ld_data,
   input  logic [AW-1:0] acc_addr,
   output logic          in_range
);
   localparam int EW = AW + 1;
   localparam logic [EW-1:0] RST_END = {1'b0, RST_BASE} + {1'b0, RST_LIMIT};

   logic [AW-1:0] base_q, limit_q, base_d, limit_d;
   logic          wr_base, wr_limit;
   logic [EW-1:0] end_w;

   assign wr_base  = ld_base  && (user_mode == pg_pkg::MODE_MON);
   assign wr_limit = ld_limit && (user_mode == pg_pkg::MODE_MON);
   assign base_d   = wr_base  ? ld_data : base_q;
   assign limit_d  = wr_limit ? ld_data : limit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= RST_BASE;
         limit_q <= RST_LIMIT;
      end else begin
         base_q  <= base_d;
         limit_q <= limit_d;
      end
   end

   generate
      if (PRECOMP) begin : g_end_reg
         logic [EW-1:0] end_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) end_q <= RST_END;
            else        end_q <= {1'b0, base_d} + {1'b0, limit_d};
         end
         assign end_w = end_q;
      end else begin : g_end_add
         assign end_w = {1'b0, base_q} + {1'b0, limit_q};
      end
   endgenerate

   assign in_range = ({1'b0, acc_addr} >= {1'b0, base_q}) &&
                     ({1'b0, acc_addr} <  end_w);

   AST_BOUNDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |=> ($stable(base_q) && $stable(limit_q))); // R7
endmodule

// File: rtl/pg_trap_arb.sv
module pg_trap_arb (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        user_mode,
   input  logic        acc_valid,
   input  logic        in_range,
   input  logic        priv_op,
   input  logic        ld_base,
   input  logic        ld_limit,
   input  logic        ret_user,
   input  logic        sys_call,
   input  logic        ext_irq,
   output logic        take_trap,
   output logic        trap_req,
   output logic [2:0]  trap_cause
);
   import pg_pkg::*;

   logic   addr_bad, illegal;
   cause_e cause_d;

   assign addr_bad = user_mode && acc_valid && !in_range;
   assign illegal  = user_mode && (priv_op || ld_base || ld_limit || ret_user);

   always_comb begin
      if (addr_bad)      cause_d = CAUSE_ADDR;
      else if (illegal)  cause_d = CAUSE_ILLEGAL;
      else if (sys_call) cause_d = CAUSE_SYSCALL;
      else if (ext_irq)  cause_d = CAUSE_IRQ;
      else               cause_d = CAUSE_NONE;
   end

   assign take_trap = (cause_d != CAUSE_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_req   <= 1'b0;
         trap_cause <= CAUSE_NONE;
      end else begin
         trap_req   <= take_trap;
         trap_cause <= cause_d;
      end
   end

   AST_RET_FROM_USER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode && ret_user && !(acc_valid && !in_range))
      |=> (trap_req && trap_cause == CAUSE_ILLEGAL)); // R10
   AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> (trap_cause == CAUSE_NONE)); // R3
endmodule

// File: rtl/pg_mode_reg.sv
module pg_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic take_trap,
   input  logic ret_user,
   output logic user_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         user_mode <= pg_pkg::MODE_MON;
      else if (take_trap)
         user_mode <= pg_pkg::MODE_MON;
      else if (ret_user && user_mode == pg_pkg::MODE_MON)
         user_mode <= pg_pkg::MODE_USER;
   end

   AST_USER_ONLY_BY_RET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode) |-> $past(ret_user)); // R2
endmodule

// File: rtl/priv_guard.sv
module priv_guard #(
   parameter int            AW        = 16,
   parameter bit            PRECOMP   = 1'b1,
   parameter logic [AW-1:0] RST_BASE  = '0,
   parameter logic [AW-1:0] RST_LIMIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic [AW-1:0] acc_addr,
   input  logic          priv_op,
   input  logic          ld_base,
   input  logic          ld_limit,
   input  logic [AW-1:0] ld_data,
   input  logic          sys_call,
   input  logic          ext_irq,
   input  logic          ret_user,
   output logic          trap_req,
   output logic [2:0]    trap_cause,
   output logic          user_mode
);
   import pg_pkg::*;

   initial begin
      assert (AW >= 4 && AW <= 64)
         else $fatal(1, "priv_guard: AW must lie in 4..64");
   end

   logic in_range;
   logic take_trap;

   pg_bounds #(
      .AW(AW), .PRECOMP(PRECOMP), .RST_BASE(RST_BASE), .RST_LIMIT(RST_LIMIT)
   ) u_bounds (
      .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
      .ld_base(ld_base), .ld_limit(ld_limit), .ld_data(ld_data),
      .acc_addr(acc_addr), .in_range(in_range)
   );

   pg_trap_arb u_arb (
      .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
      .acc_valid(acc_valid), .in_range(in_range), .priv_op(priv_op),
      .ld_base(ld_base), .ld_limit(ld_limit), .ret_user(ret_user),
      .sys_call(sys_call), .ext_irq(ext_irq), .take_trap(take_trap),
      .trap_req(trap_req), .trap_cause(trap_cause)
   );

   pg_mode_reg u_mode (
      .clk(clk), .rst_n(rst_n), .take_trap(take_trap),
      .ret_user(ret_user), .user_mode(user_mode)
   );

   AST_TRAP_FORCES_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (user_mode == MODE_MON)); // R3
   AST_ADDR_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode && acc_valid && !in_range) |=> (trap_req && trap_cause == CAUSE_ADDR)); // R9
   AST_MONITOR_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode == MODE_MON) |=> (trap_cause != CAUSE_ADDR)); // R8
endmodule

// File: tb/sim_priv_guard.sv
module sim_priv_guard;
   localparam int CLK_P = 10;
   localparam int AW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0, priv_op = 1'b0, ld_base = 1'b0, ld_limit = 1'b0;
   logic          sys_call = 1'b0, ext_irq = 1'b0, ret_user = 1'b0;
   logic [AW-1:0] acc_addr = '0, ld_data = '0;
   logic          trap_req, user_mode;
   logic [2:0]    trap_cause;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   priv_guard #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .priv_op(priv_op), .ld_base(ld_base), .ld_limit(ld_limit), .ld_data(ld_data),
      .sys_call(sys_call), .ext_irq(ext_irq), .ret_user(ret_user),
      .trap_req(trap_req), .trap_cause(trap_cause), .user_mode(user_mode)
   );

   task automatic clr();
      acc_valid = 0; priv_op = 0; ld_base = 0; ld_limit = 0;
      sys_call = 0; ext_irq = 0; ret_user = 0;
   endtask

   task automatic tick();
      @(posedge clk); #1; clr();
   endtask

   task automatic expect_out(input logic er, input logic [2:0] ec, input logic em, input string tag);
      total++;
      if (trap_req !== er || trap_cause !== ec || user_mode !== em) begin
         bad++;
         $display("FAIL %s: req/cause/mode actual=%0b/%0d/%0b expected=%0b/%0d/%0b",
                  tag, trap_req, trap_cause, user_mode, er, ec, em);
      end
   endtask

   task automatic go_user();
      ret_user = 1; tick();
      expect_out(0, 0, 1, "R2 return to user");
   endtask

   task automatic load(input logic [AW-1:0] b, input logic [AW-1:0] l);
      ld_base = 1; ld_data = b; tick();
      ld_limit = 1; ld_data = l; tick();
   endtask

   task automatic user_access(input logic [AW-1:0] a, input logic viol, input string tag);
      go_user();
      acc_valid = 1; acc_addr = a; tick();
      if (viol) expect_out(1, 2, 0, tag);
      else begin
         expect_out(0, 0, 1, tag);
         sys_call = 1; tick();          // leave user mode for the next scenario
         expect_out(1, 3, 0, "R9 syscall exit");
      end
   endtask

   task automatic t_reset();
      expect_out(0, 0, 0, "R1 reset state");
      user_access(16'h0000, 1, "R1 zero window traps");
   endtask

   task automatic t_window();
      load(16'h0100, 16'h0040);
      acc_valid = 1; acc_addr = 16'h0000; tick();
      expect_out(0, 0, 0, "R8 monitor access unchecked");
      acc_valid = 1; acc_addr = 16'hFFFF; tick();
      expect_out(0, 0, 0, "R8 monitor high access");
      user_access(16'h0100, 0, "R5 base legal");
      user_access(16'h013F, 0, "R5 last legal");
      user_access(16'h0140, 1, "R6 end excluded");
      user_access(16'h00FF, 1, "R6 below base");
      tick();
      expect_out(0, 0, 0, "R3 trap pulse ends");
   endtask

   task automatic t_priv();
      go_user(); priv_op = 1; tick();
      expect_out(1, 1, 0, "R4 privileged op in user");
      priv_op = 1; tick();
      expect_out(0, 0, 0, "R4 privileged op in monitor");
      go_user(); ld_base = 1; ld_data = 16'h0000; tick();
      expect_out(1, 1, 0, "R7 base load in user");
      go_user(); ld_limit = 1; ld_data = 16'h0001; tick();
      expect_out(1, 1, 0, "R7 limit load in user");
      user_access(16'h0100, 0, "R7 base kept");
      user_access(16'h0000, 1, "R7 old base still low edge");
      user_access(16'h0140, 1, "R7 limit kept");
      go_user(); ret_user = 1; tick();
      expect_out(1, 1, 0, "R10 return from user");
   endtask

   task automatic t_events();
      go_user(); sys_call = 1; tick();
      expect_out(1, 3, 0, "R9 syscall in user");
      go_user(); ext_irq = 1; tick();
      expect_out(1, 4, 0, "R9 irq in user");
      ext_irq = 1; tick();
      expect_out(1, 4, 0, "R9 irq in monitor");
      ret_user = 1; sys_call = 1; tick();
      expect_out(1, 3, 0, "R3 trap beats return");
      go_user(); acc_valid = 1; acc_addr = 16'h0200; sys_call = 1; priv_op = 1; tick();
      expect_out(1, 2, 0, "R9 address first");
      go_user(); priv_op = 1; ext_irq = 1; sys_call = 1; tick();
      expect_out(1, 1, 0, "R9 illegal before syscall");
      go_user(); sys_call = 1; ext_irq = 1; tick();
      expect_out(1, 3, 0, "R9 syscall before irq");
   endtask

   task automatic t_wrap();
      load(16'hFFF0, 16'h0020);
      user_access(16'hFFFF, 0, "R11 top address legal");
      user_access(16'h0005, 1, "R11 no wrap");
      load(16'h0300, 16'h0000);
      user_access(16'h0300, 1, "R5 empty window");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_window();
      t_priv();
      t_events();
      t_wrap();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule